// File: doc/BRIEF.md
# Machine-Mode CSR and Trap Controller

This block keeps the machine-level control and status registers of a small 32-bit RISC-V style core and tracks which privilege level the hart is running at. The execute stage presents a CSR request (address, operand and a 2-bit operation). In the same cycle the block answers with the old register value and a combinational illegal-access flag, so the core can turn a bad access into an illegal-instruction trap without waiting a cycle. A legal write takes effect at the next clock edge.

Two pulse inputs drive control flow. A trap-entry pulse comes with a cause word and the faulting PC. A return pulse leaves the trap handler. For either pulse the block drives the redirect PC combinationally in the same cycle and updates the status word and the privilege level at the clock edge. The privilege level is a four-state machine with the states USER (0), SUPER (1), HYPER (2) and MACHINE (3). It has two named transitions. TAKE_TRAP goes from any state to MACHINE. RETURN goes from any state to the state saved in status bits [12:11]. With no pulse it holds its state.

Top module: `mcsr_trap_unit`

## Requirements
- R1: After reset the privilege output is 3 (machine). The status, interrupt-enable, vector base, scratch, exception-PC, cause and cycle registers all read zero.
- R2: A request is illegal when any address bit above bit 11 is set, when address bits [9:8] are numerically greater than the current privilege, when the address is not implemented, or when the operation code is 3. The flag is combinational with the request and is low without a request. An illegal request changes no state, and read data is zero for an illegal or absent request.
- R3: Address 0x301 reads 0x40101105. Addresses 0xF11 to 0xF14, 0x343 and 0x344 read zero. Writes to any of these are legal and have no effect.
- R4: A write to 0x305 (vector base) forces bit 1 to zero. A write to 0x341 (exception PC) forces bit 0 to zero. A write to 0x342 (cause) keeps only the bits of 0x800000FF.
- R5: Operation code 0 writes the operand, 1 ORs it into the current value, and 2 clears the operand's set bits. Every legal request returns the value the register held before the edge.
- R6: The cycle counter at 0xB00 increases by one every clock. A write to it in a cycle wins over the increment. Address 0xB02 reads the same counter, and writes to 0xB02 load it.
- R7: On trap entry, status bits [12:11] take the old privilege, bit 7 is set if bit 3 was set (and otherwise keeps its value), and bit 3 is cleared. The privilege becomes 3, the cause register takes the cause word, and the exception PC takes the faulting PC.
- R8: The trap redirect PC is the vector base with bit 0 cleared. When base bit 0 is set and cause bit 31 is set, it is that base plus 4 times the cause with bit 31 removed.
- R9: On return, the privilege takes status bits [12:11], bit 3 is set if bit 7 was set, and bit 7 is cleared. The redirect PC is the exception-PC register.
- R10: A trap or return pulse in the same cycle as a CSR request drops that request's write. A trap pulse wins over a simultaneous return pulse.
- R11: The redirect PC output is zero in any cycle with neither a trap nor a return pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_req | input | 1 | CSR access request this cycle |
| csr_addr | input | 16 | CSR address (bits above 11 must be zero) |
| csr_op | input | 2 | 0 write, 1 set, 2 clear, 3 reserved |
| csr_wdata | input | 32 | Operand for the access |
| csr_rdata | output | 32 | Value held before the edge, zero if illegal or idle |
| csr_illegal | output | 1 | Combinational illegal-access flag |
| trap_req | input | 1 | Trap entry pulse |
| trap_cause | input | 32 | Cause word, bit 31 marks an interrupt |
| trap_pc | input | 32 | PC of the trapping instruction |
| mret_req | input | 1 | Return-from-trap pulse |
| redirect_pc | output | 32 | Fetch target for a trap or return |
| priv_level | output | 2 | Current privilege level |

## Verification
The hazardous overlap is a CSR write landing in the same cycle as a trap entry or a return. Both want to update the status, cause and exception-PC registers. The bench provokes this by pulsing trap entry while writing the scratch and status registers, and by pulsing trap and return together. It then judges the outcome by reading the registers back in later cycles and by watching the privilege output. The same-edge race between a counter write and the counter's own increment is also driven directly. The cycle-by-cycle model predicts the written value.

// File: rtl/mcsr_pkg.sv
package mcsr_pkg;
    localparam int XLEN = 32;

    typedef enum logic [1:0] {
        PRIV_USER  = 2'd0,
        PRIV_SUPER = 2'd1,
        PRIV_HYPER = 2'd2,
        PRIV_MACH  = 2'd3
    } priv_e;

    typedef enum logic [1:0] {
        OP_WRITE = 2'd0,
        OP_SET   = 2'd1,
        OP_CLEAR = 2'd2,
        OP_RSVD  = 2'd3
    } csr_op_e;

    typedef enum logic [1:0] {
        EV_NONE = 2'd0,
        EV_TAKE_TRAP = 2'd1,
        EV_RETURN = 2'd2
    } ctl_ev_e;

    typedef enum logic [3:0] {
        ID_NONE, ID_STATUS, ID_ISA, ID_IE, ID_TVEC, ID_SCRATCH, ID_EPC,
        ID_CAUSE, ID_TVAL, ID_IP, ID_CYCLE, ID_INSTRET, ID_VENDOR,
        ID_ARCH, ID_IMP, ID_HART
    } csr_id_e;

    localparam logic [XLEN-1:0] ISA_VALUE  = 32'h4010_1105;
    localparam logic [XLEN-1:0] TVEC_MASK  = 32'hFFFF_FFFD;
    localparam logic [XLEN-1:0] EPC_MASK   = 32'hFFFF_FFFE;
    localparam logic [XLEN-1:0] CAUSE_MASK = 32'h8000_00FF;

    localparam int ST_IE   = 3;
    localparam int ST_PIE  = 7;
    localparam int ST_PP_LO = 11;
    localparam int ST_PP_HI = 12;
endpackage

// File: rtl/mcsr_decode.sv
module mcsr_decode
    import mcsr_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        op,
    input  logic [1:0]        priv,
    output csr_id_e           id,
    output logic              bad
);
    logic hi_bits;

    generate
        if (ADDR_W > 12) begin : g_wide
            assign hi_bits = |addr[ADDR_W-1:12];
        end else begin : g_narrow
            assign hi_bits = 1'b0;
        end
    endgenerate

    always_comb begin
        unique case (addr[11:0])
            12'h300: id = ID_STATUS;
            12'h301: id = ID_ISA;
            12'h304: id = ID_IE;
            12'h305: id = ID_TVEC;
            12'h340: id = ID_SCRATCH;
            12'h341: id = ID_EPC;
            12'h342: id = ID_CAUSE;
            12'h343: id = ID_TVAL;
            12'h344: id = ID_IP;
            12'hB00: id = ID_CYCLE;
            12'hB02: id = ID_INSTRET;
            12'hF11: id = ID_VENDOR;
            12'hF12: id = ID_ARCH;
            12'hF13: id = ID_IMP;
            12'hF14: id = ID_HART;
            default: id = ID_NONE;
        endcase
    end

    assign bad = hi_bits
               || (addr[9:8] > priv)
               || (id == ID_NONE)
               || (op == OP_RSVD);
endmodule

// File: rtl/mcsr_priv_fsm.sv
module mcsr_priv_fsm
    import mcsr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  ctl_ev_e    ev,
    input  logic [1:0] ret_priv,
    output priv_e      priv
);
    priv_e cur, nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur <= PRIV_MACH;
        else        cur <= nxt;
    end

    always_comb begin
        nxt = cur;
        unique case (ev)
            EV_TAKE_TRAP: nxt = PRIV_MACH;
            EV_RETURN:    nxt = priv_e'(ret_priv);
            default:      nxt = cur;
        endcase
    end

    assign priv = cur;
endmodule

// File: rtl/mcsr_trap_target.sv
module mcsr_trap_target
    import mcsr_pkg::*;
(
    input  logic [XLEN-1:0] tvec,
    input  logic            is_irq,
    input  logic [XLEN-3:0] code,
    output logic [XLEN-1:0] target
);
    logic [XLEN-1:0] base;

    assign base = {tvec[XLEN-1:1], 1'b0};

    always_comb begin
        if (tvec[0] && is_irq) target = base + {code, 2'b00};
        else                   target = base;
    end
endmodule

// File: rtl/mcsr_trap_unit.sv
module mcsr_trap_unit
    import mcsr_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csr_req,
    input  logic [ADDR_W-1:0] csr_addr,
    input  logic [1:0]        csr_op,
    input  logic [XLEN-1:0]   csr_wdata,
    output logic [XLEN-1:0]   csr_rdata,
    output logic              csr_illegal,
    input  logic              trap_req,
    input  logic [XLEN-1:0]   trap_cause,
    input  logic [XLEN-1:0]   trap_pc,
    input  logic              mret_req,
    output logic [XLEN-1:0]   redirect_pc,
    output logic [1:0]        priv_level
);
    logic [XLEN-1:0] r_status, r_ie, r_tvec, r_scratch, r_epc, r_cause, r_cycle;
    logic [XLEN-1:0] rd_val, wr_val, vec_target, st_next;
    csr_id_e         id;
    logic            bad, legal_req, do_write;
    ctl_ev_e         ev;
    priv_e           priv;

    mcsr_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr (csr_addr),
        .op   (csr_op),
        .priv (priv),
        .id   (id),
        .bad  (bad)
    );

    always_comb begin
        if (trap_req)      ev = EV_TAKE_TRAP;
        else if (mret_req) ev = EV_RETURN;
        else               ev = EV_NONE;
    end

    mcsr_priv_fsm u_priv (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev       (ev),
        .ret_priv (r_status[ST_PP_HI:ST_PP_LO]),
        .priv     (priv)
    );

    mcsr_trap_target u_target (
        .tvec   (r_tvec),
        .is_irq (trap_cause[XLEN-1]),
        .code   (trap_cause[XLEN-3:0]),
        .target (vec_target)
    );

    assign legal_req = csr_req && !bad;
    assign do_write  = legal_req && (ev == EV_NONE);

    always_comb begin
        unique case (id)
            ID_STATUS:             rd_val = r_status;
            ID_ISA:                rd_val = ISA_VALUE;
            ID_IE:                 rd_val = r_ie;
            ID_TVEC:               rd_val = r_tvec;
            ID_SCRATCH:            rd_val = r_scratch;
            ID_EPC:                rd_val = r_epc;
            ID_CAUSE:              rd_val = r_cause;
            ID_CYCLE, ID_INSTRET:  rd_val = r_cycle;
            default:               rd_val = '0;
        endcase
    end

    always_comb begin
        unique case (csr_op_e'(csr_op))
            OP_WRITE: wr_val = csr_wdata;
            OP_SET:   wr_val = rd_val | csr_wdata;
            OP_CLEAR: wr_val = rd_val & ~csr_wdata;
            default:  wr_val = rd_val;
        endcase
    end

    always_comb begin
        st_next = r_status;
        unique case (ev)
            EV_TAKE_TRAP: begin
                st_next[ST_PP_HI:ST_PP_LO] = priv;
                if (r_status[ST_IE]) st_next[ST_PIE] = 1'b1;
                st_next[ST_IE] = 1'b0;
            end
            EV_RETURN: begin
                if (r_status[ST_PIE]) st_next[ST_IE] = 1'b1;
                st_next[ST_PIE] = 1'b0;
            end
            default: begin
                if (do_write && id == ID_STATUS) st_next = wr_val;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_status  <= '0;
            r_ie      <= '0;
            r_tvec    <= '0;
            r_scratch <= '0;
            r_epc     <= '0;
            r_cause   <= '0;
            r_cycle   <= '0;
        end else begin
            r_status <= st_next;
            if (do_write && (id == ID_CYCLE || id == ID_INSTRET)) r_cycle <= wr_val;
            else                                                   r_cycle <= r_cycle + 1'b1;
            if (ev == EV_TAKE_TRAP) begin
                r_cause <= trap_cause;
                r_epc   <= trap_pc;
            end else if (do_write) begin
                if (id == ID_CAUSE) r_cause <= wr_val & CAUSE_MASK;
                if (id == ID_EPC)   r_epc   <= wr_val & EPC_MASK;
            end
            if (do_write && id == ID_IE)      r_ie      <= wr_val;
            if (do_write && id == ID_TVEC)    r_tvec    <= wr_val & TVEC_MASK;
            if (do_write && id == ID_SCRATCH) r_scratch <= wr_val;
        end
    end

    always_comb begin
        unique case (ev)
            EV_TAKE_TRAP: redirect_pc = vec_target;
            EV_RETURN:    redirect_pc = r_epc;
            default:      redirect_pc = '0;
        endcase
    end

    assign csr_rdata   = legal_req ? rd_val : '0;
    assign csr_illegal = csr_req && bad;
    assign priv_level  = priv;
endmodule

// File: rtl/mcsr_trap_checker.sv
module mcsr_trap_checker #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              csr_req,
    input logic [ADDR_W-1:0] csr_addr,
    input logic [1:0]        csr_op,
    input logic [31:0]       csr_wdata,
    input logic [31:0]       csr_rdata,
    input logic              csr_illegal,
    input logic              trap_req,
    input logic [31:0]       trap_cause,
    input logic [31:0]       trap_pc,
    input logic              mret_req,
    input logic [31:0]       redirect_pc,
    input logic [1:0]        priv_level
);
    assert_idle_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !csr_req |-> !csr_illegal);

    assert_reserved_op_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_req && csr_op == 2'd3) |-> csr_illegal);

    assert_illegal_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        csr_illegal |-> (csr_rdata == 32'd0));

    assert_isa_const_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_req && !csr_illegal && csr_addr == 16'h0301) |-> (csr_rdata == 32'h4010_1105));

    assert_trap_mach_R7: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |=> (priv_level == 2'd3));

    assert_target_even_R8: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> (redirect_pc[0] == 1'b0));

    assert_priv_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!trap_req && !mret_req) |=> $stable(priv_level));

    assert_idle_redirect_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!trap_req && !mret_req) |-> (redirect_pc == 32'd0));
endmodule

bind mcsr_trap_unit mcsr_trap_checker #(.ADDR_W(ADDR_W)) i_chk (.*);

// File: tb/test_mcsr_trap_unit.sv
module test_mcsr_trap_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        csr_req = 1'b0;
    logic [15:0] csr_addr = '0;
    logic [1:0]  csr_op = '0;
    logic [31:0] csr_wdata = '0;
    logic [31:0] csr_rdata;
    logic        csr_illegal;
    logic        trap_req = 1'b0;
    logic [31:0] trap_cause = '0;
    logic [31:0] trap_pc = '0;
    logic        mret_req = 1'b0;
    logic [31:0] redirect_pc;
    logic [1:0]  priv_level;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // reference state
    int          m_priv;
    logic [31:0] m_st, m_ie, m_tvec, m_scr, m_epc, m_cause, m_cyc;

    always #(CLK_PERIOD/2) clk = ~clk;

    mcsr_trap_unit i_mcsr_trap_unit (
        .clk(clk), .rst_n(rst_n), .csr_req(csr_req), .csr_addr(csr_addr),
        .csr_op(csr_op), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
        .csr_illegal(csr_illegal), .trap_req(trap_req), .trap_cause(trap_cause),
        .trap_pc(trap_pc), .mret_req(mret_req), .redirect_pc(redirect_pc),
        .priv_level(priv_level)
    );

    task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %08h expected %08h", tag, what, act, exp);
        end
    endtask

    function automatic bit model_read(input int addr, output logic [31:0] val);
        val = 32'd0;
        if (addr >= 4096 || ((addr >> 8) & 3) > m_priv) return 1'b0;
        case (addr)
            'h300: val = m_st;
            'h301: val = 32'h4010_1105;
            'h304: val = m_ie;
            'h305: val = m_tvec;
            'h340: val = m_scr;
            'h341: val = m_epc;
            'h342: val = m_cause;
            'hB00, 'hB02: val = m_cyc;
            'h343, 'h344, 'hF11, 'hF12, 'hF13, 'hF14: val = 32'd0;
            default: return 1'b0;
        endcase
        return 1'b1;
    endfunction

    task automatic step(input bit req, input int addr, input int op, input logic [31:0] wd,
                        input bit trap, input logic [31:0] cause, input logic [31:0] pc,
                        input bit ret, input string tag);
        logic [31:0] val, opnd, e_red, n_st, n_cyc;
        bit legal;
        int n_priv;
        csr_req = req; csr_addr = addr[15:0]; csr_op = op[1:0]; csr_wdata = wd;
        trap_req = trap; trap_cause = cause; trap_pc = pc; mret_req = ret;
        #1;
        legal = model_read(addr, val) && (op != 3);
        if (!legal) val = 32'd0;
        if (trap) begin
            e_red = m_tvec & ~32'd1;
            if (m_tvec[0] && cause[31]) e_red = e_red + 4 * (cause & 32'h7FFF_FFFF);
        end else if (ret) e_red = m_epc;
        else e_red = 32'd0;
        check(tag, "illegal", {31'd0, csr_illegal}, {31'd0, req && !legal});
        check(tag, "rdata", csr_rdata, (req && legal) ? val : 32'd0);
        check((trap || ret) ? tag : "R11", "redirect", redirect_pc, e_red);
        check(tag, "priv", {30'd0, priv_level}, m_priv);
        // next state
        n_st = m_st; n_priv = m_priv; n_cyc = m_cyc + 1;
        opnd = (op == 0) ? wd : (op == 1) ? (val | wd) : (val & ~wd);
        if (trap) begin
            n_st[12:11] = m_priv[1:0];
            if (m_st[3]) n_st[7] = 1'b1;
            n_st[3] = 1'b0;
            n_priv = 3;
            m_cause = cause;
            m_epc = pc;
        end else if (ret) begin
            n_priv = m_st[12:11];
            if (m_st[7]) n_st[3] = 1'b1;
            n_st[7] = 1'b0;
        end else if (req && legal) begin
            case (addr)
                'h300: n_st = opnd;
                'h304: m_ie = opnd;
                'h305: m_tvec = opnd & 32'hFFFF_FFFD;
                'h340: m_scr = opnd;
                'h341: m_epc = opnd & 32'hFFFF_FFFE;
                'h342: m_cause = opnd & 32'h8000_00FF;
                'hB00, 'hB02: n_cyc = opnd;
                default: ;
            endcase
        end
        @(posedge clk);
        m_st = n_st; m_priv = n_priv; m_cyc = n_cyc;
        @(negedge clk);
    endtask

    task automatic rd(input int addr, input string tag);
        step(1, addr, 1, 32'd0, 0, 0, 0, 0, tag);
    endtask

    task automatic wr(input int addr, input int op, input logic [31:0] wd, input string tag);
        step(1, addr, op, wd, 0, 0, 0, 0, tag);
    endtask

    initial begin
        while (cycles < 5000) begin
            @(posedge clk);
            cycles++;
        end
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d expected <5000 cycles", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        m_priv = 3; m_st = 0; m_ie = 0; m_tvec = 0; m_scr = 0; m_epc = 0; m_cause = 0; m_cyc = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        step(0, 0, 0, 0, 0, 0, 0, 0, "R1");
        m_cyc = 32'd1;
        rd('h300, "R1"); rd('h305, "R1"); rd('h341, "R1"); rd('h342, "R1");
        // R3 constants, ignored writes
        rd('h301, "R3"); rd('hF11, "R3"); rd('hF14, "R3"); rd('h343, "R3");
        wr('h301, 0, 32'hFFFF_FFFF, "R3"); rd('h301, "R3");
        wr('h344, 0, 32'hFFFF_FFFF, "R3"); rd('h344, "R3");
        wr('hF13, 0, 32'h1234_5678, "R3"); rd('hF13, "R3");
        // R5 write / set / clear
        wr('h340, 0, 32'hA5A5_0F0F, "R5");
        wr('h340, 1, 32'h0000_F000, "R5");
        wr('h340, 2, 32'h0000_000F, "R5");
        rd('h340, "R5");
        wr('h304, 0, 32'h0000_0888, "R5"); wr('h304, 2, 32'h0000_0008, "R5"); rd('h304, "R5");
        // R4 masks
        wr('h305, 0, 32'hFFFF_FFFF, "R4"); rd('h305, "R4");
        wr('h341, 0, 32'hFFFF_FFFF, "R4"); rd('h341, "R4");
        wr('h342, 0, 32'hFFFF_FFFF, "R4"); rd('h342, "R4");
        // R6 cycle counter and alias
        rd('hB00, "R6"); rd('hB00, "R6");
        wr('hB00, 0, 32'd100, "R6"); rd('hB00, "R6"); rd('hB02, "R6");
        wr('hB02, 0, 32'd500, "R6"); rd('hB00, "R6");
        wr('hB00, 1, 32'h0001_0000, "R6"); rd('hB02, "R6");
        // R2 illegal cases, state untouched
        rd('h345, "R2"); rd('h1340, "R2"); rd('h8300, "R2");
        wr('h340, 3, 32'hFFFF_FFFF, "R2"); rd('h340, "R2");
        wr('h2340, 0, 32'd0, "R2"); rd('h340, "R2");
        // R7/R8 direct trap with interrupts enabled
        wr('h305, 0, 32'h0000_1000, "R8");
        wr('h300, 0, 32'h0000_0008, "R7");
        step(0, 0, 0, 0, 1, 32'd2, 32'h0000_2004, 0, "R7");
        rd('h300, "R7"); rd('h341, "R7"); rd('h342, "R7");
        // R8 interrupt cause with direct base
        step(0, 0, 0, 0, 1, 32'h8000_0003, 32'h0000_2008, 0, "R8");
        // R9 return to user
        wr('h305, 0, 32'h0000_1001, "R8");
        wr('h300, 0, 32'h0000_0080, "R9");
        wr('h341, 0, 32'h0000_3000, "R9");
        step(0, 0, 0, 0, 0, 0, 0, 1, "R9");
        rd('h340, "R2"); rd('hF11, "R2"); rd('hB00, "R2");
        // R8 vectored interrupt from user, then exception
        step(0, 0, 0, 0, 1, 32'h8000_0007, 32'h0000_3004, 0, "R8");
        rd('h300, "R7");
        step(0, 0, 0, 0, 1, 32'd5, 32'h0000_1010, 0, "R8");
        rd('h300, "R7"); rd('h342, "R7");
        // R10 overlaps
        step(1, 'h340, 0, 32'hDEAD_BEEF, 1, 32'd11, 32'h0000_4000, 0, "R10");
        rd('h340, "R10"); rd('h341, "R10");
        step(1, 'h300, 0, 32'h0000_1888, 0, 0, 0, 1, "R10");
        rd('h300, "R10");
        wr('h300, 0, 32'h0000_0080, "R10");
        step(0, 0, 0, 0, 1, 32'd3, 32'h0000_5000, 1, "R10");
        rd('h300, "R10"); rd('h341, "R10");
        step(1, 'hB00, 0, 32'd7, 1, 32'd3, 32'h0000_5004, 0, "R10");
        rd('hB00, "R10");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule